// File: doc/BRIEF.md
# Hierarchical Toggle-Preference Round-Robin Arbiter

This block picks one winner per cell time slot among N request lines. It is built as a tree of two-input decision cells. Each cell holds a single preference bit that names which side wins a tie. Four-input modules group three cells: two leaf cells, each serving a pair of inputs, and one middle cell that chooses between the two pairs. Four-input modules are stacked in layers, so a 16-input arbiter is four lower modules under one upper module, and a 64-input arbiter adds one more layer.

Requests travel up the tree through an OR network. Grants travel down, and each cell's local decision is ANDed with every grant from above. The grant outputs are combinational within the slot. A slot strobe advances every preference bit together, and a cell updates its bit only when its own group was granted. Fairness is therefore spread over the tree instead of kept in one central pointer. The block also exports an OR of all its requests and accepts a grant from above, so a whole arbiter can act as one group inside a larger one.

Top module: `pp_tree_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every preference bit. Afterwards, with every input requesting and the upper grant high, input 0 wins. With no requests, all grant outputs are 0.
- R2: In each cell a preference bit of 0 makes the lower-index side win a tie, and a value of 1 makes the higher-index side win.
- R3: When a granted cell awards its lower side, its preference bit becomes 1. When it awards its higher side, the bit becomes 0. The new value takes effect only at a rising clock edge with the slot strobe high.
- R4: With the upper grant high, a lone requesting input is granted, whatever the preference state.
- R5: At most one grant output is high at any time. With the upper grant high and at least one request, exactly one grant output is high.
- R6: A grant output is never high while its request input is low.
- R7: With the upper grant low, every grant output is 0, and slot strobes leave every preference bit unchanged.
- R8: The group request output equals the OR of all request inputs, whatever the upper grant.
- R9: With every input requesting from reset and one strobe per slot, slot s grants the input whose index is the bit-reversal of s over log2(N) bits. Each input therefore wins exactly once in N slots.
- R10: No input is granted in two consecutive strobed slots while another input requests and the upper grant stays high.
- R11: A cell whose group has no request when a strobe arrives keeps its preference bit.
- R12: Without a slot strobe, the grant stays the same for a fixed request pattern across any number of clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_i | input | 1 | Slot strobe; preference bits update at this edge |
| req_i | input | N | Request lines, one per input |
| gnt_i | input | 1 | Grant from the layer above (tie high at the root) |
| gnt_o | output | N | Grant lines, at most one high |
| grp_req_o | output | 1 | OR of all requests, sent to the layer above |

## Verification
Several request patterns are used, and each exposes a different fault. All inputs requesting continuously checks the full bit-reversed rotation, which catches a wrong tie rule or a wrong flag update in any cell at any layer. A single requester at every position catches broken grant paths. A pair of requesters in different modules shows that the decision happens at their common cell. A request from input 1 alone, followed by a request from 0 and 1, shows that a grant to the higher side sets the preference low. Slots with the upper grant low, with no requests, or without a strobe show that preference bits hold when they should.

// File: rtl/pp_arb_pkg.sv
package pp_arb_pkg;

    typedef enum logic {
        PREF_LO = 1'b0,
        PREF_HI = 1'b1
    } pref_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } cell_gnt_t;

    // Local decision of one two-input cell, before upper grants are applied.
    function automatic cell_gnt_t cell_pick(input logic [1:0] r, input pref_e f);
        cell_gnt_t g;
        g.lo = r[0] & (~r[1] | (f == PREF_LO));
        g.hi = r[1] & (~r[0] | (f == PREF_HI));
        return g;
    endfunction

    // Preference for the next slot; unchanged unless this cell's group won.
    function automatic pref_e next_pref(input cell_gnt_t g, input logic up_ok, input pref_e f);
        if (!up_ok)   return f;
        if (g.lo)     return PREF_HI;
        if (g.hi)     return PREF_LO;
        return f;
    endfunction

    // Bit offset of tree level k inside the flattened request/grant vectors.
    function automatic int lvl_off(input int n, input int k);
        int s;
        s = 0;
        for (int i = 0; i < k; i++) s += n >> (2 * i);
        return s;
    endfunction

endpackage

// File: rtl/pp_cell.sv
module pp_cell
    import pp_arb_pkg::*;
#(
    parameter int NUP = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           slot_i,
    input  logic [1:0]     req_i,
    input  logic [NUP-1:0] up_i,
    output logic [1:0]     gnt_o
);

    pref_e     pref_q;
    pref_e     pref_d;
    cell_gnt_t loc;
    logic      up_ok;

    always_comb begin
        loc    = cell_pick(req_i, pref_q);
        up_ok  = &up_i;
        // upper grants join at the final gate stage
        gnt_o  = {loc.hi & up_ok, loc.lo & up_ok};
        pref_d = next_pref(loc, up_ok, pref_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pref_q <= PREF_LO;
        else if (slot_i)
            pref_q <= pref_d;
    end

endmodule

// File: rtl/pp_quad.sv
module pp_quad (
    input  logic       clk,
    input  logic       rst,
    input  logic       slot_i,
    input  logic [3:0] req_i,
    input  logic       ext_gnt_i,
    output logic [3:0] gnt_o,
    output logic       grp_req_o
);

    logic [1:0] pair_req;
    logic [1:0] pair_gnt;

    assign pair_req  = {|req_i[3:2], |req_i[1:0]};
    assign grp_req_o = |req_i;

    pp_cell #(.NUP(1)) mid_i (
        .clk    (clk),
        .rst    (rst),
        .slot_i (slot_i),
        .req_i  (pair_req),
        .up_i   (ext_gnt_i),
        .gnt_o  (pair_gnt)
    );

    for (genvar p = 0; p < 2; p++) begin : g_leaf
        pp_cell #(.NUP(2)) leaf_i (
            .clk    (clk),
            .rst    (rst),
            .slot_i (slot_i),
            .req_i  (req_i[2*p +: 2]),
            .up_i   ({pair_gnt[p], ext_gnt_i}),
            .gnt_o  (gnt_o[2*p +: 2])
        );
    end

endmodule

// File: rtl/pp_tree_arbiter.sv
module pp_tree_arbiter
    import pp_arb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         slot_i,
    input  logic [N-1:0] req_i,
    input  logic         gnt_i,
    output logic [N-1:0] gnt_o,
    output logic         grp_req_o
);

    localparam int LEVELS = $clog2(N) / 2;
    localparam int TOT    = (4 * N - 1) / 3;

    if (N < 4 || (1 << (2 * LEVELS)) != N) begin : g_bad_n
        $error("pp_tree_arbiter: N must be a power of 4, at least 4");
    end

    // Flattened per-level vectors: level 0 is the inputs, the last bit is the root.
    logic [TOT-1:0] rq;
    logic [TOT-1:0] gt;

    assign rq[N-1:0]   = req_i;
    assign gnt_o       = gt[N-1:0];
    assign grp_req_o   = rq[TOT-1];
    assign gt[TOT-1]   = gnt_i;

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam int W    = N >> (2 * k);
        localparam int IOFF = lvl_off(N, k);
        localparam int OOFF = lvl_off(N, k + 1);
        for (genvar j = 0; j < W / 4; j++) begin : g_mod
            pp_quad quad_i (
                .clk       (clk),
                .rst       (rst),
                .slot_i    (slot_i),
                .req_i     (rq[IOFF + 4*j +: 4]),
                .ext_gnt_i (gt[OOFF + j]),
                .gnt_o     (gt[IOFF + 4*j +: 4]),
                .grp_req_o (rq[OOFF + j])
            );
        end
    end

endmodule

// File: rtl/pp_tree_arbiter_chk.sv
module pp_tree_arbiter_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         slot_i,
    input logic [N-1:0] req_i,
    input logic         gnt_i,
    input logic [N-1:0] gnt_o,
    input logic         grp_req_o
);

    // R5: never more than one winner
    a_r5_at_most_one: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    // R5: a winner whenever someone asks and the tree is enabled
    a_r5_exactly_one: assert property (@(posedge clk) disable iff (rst)
        (gnt_i && (req_i != '0)) |-> ($countones(gnt_o) == 1));

    // R6: grants only to requesters
    a_r6_req_only: assert property (@(posedge clk) disable iff (rst)
        ((gnt_o & ~req_i) == '0));

    // R7: blocked from above means no grant
    a_r7_blocked: assert property (@(posedge clk) disable iff (rst)
        !gnt_i |-> (gnt_o == '0));

    // R8: group request follows the requests
    a_r8_group_req: assert property (@(posedge clk) disable iff (rst)
        grp_req_o == (req_i != '0));

    // R10: last slot's winner loses to any other requester
    a_r10_no_repeat: assert property (@(posedge clk) disable iff (rst)
        ($past(slot_i) && $past(gnt_i) && gnt_i && ($past(gnt_o) != '0)
         && ((req_i & ~$past(gnt_o)) != '0))
        |-> ((gnt_o & $past(gnt_o)) == '0));

endmodule

bind pp_tree_arbiter pp_tree_arbiter_chk #(.N(N)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .slot_i    (slot_i),
    .req_i     (req_i),
    .gnt_i     (gnt_i),
    .gnt_o     (gnt_o),
    .grp_req_o (grp_req_o)
);

// File: tb/pp_tree_arbiter_tb.sv
`timescale 1ns/1ps
module pp_tree_arbiter_tb_top;

    localparam int N    = 16;
    localparam int BITS = $clog2(N);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         slot_i = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         gnt_i = 1'b1;
    logic [N-1:0] gnt_o;
    logic         grp_req_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pp_tree_arbiter #(.N(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .slot_i    (slot_i),
        .req_i     (req_i),
        .gnt_i     (gnt_i),
        .gnt_o     (gnt_o),
        .grp_req_o (grp_req_o)
    );

    function automatic logic [N-1:0] onehot(input int i);
        return N'(1) << i;
    endfunction

    function automatic int bitrev(input int s);
        int r;
        r = 0;
        for (int b = 0; b < BITS; b++) if (s[b]) r |= 1 << (BITS - 1 - b);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_i = '0; gnt_i = 1'b1; slot_i = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_slot();
        slot_i = 1'b1;
        @(posedge clk);
        #1 slot_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_in(input logic [N-1:0] r, input logic up);
        req_i = r; gnt_i = up;
        #1;
    endtask

    task automatic t_reset_state();
        do_reset();
        set_in('0, 1'b1);
        chk("R1 idle grant", gnt_o, '0);
        chk("R8 idle group req", N'(grp_req_o), N'(0));
        set_in('1, 1'b1);
        chk("R1 input0 wins after reset", gnt_o, onehot(0));
        chk("R8 group req with requests", N'(grp_req_o), N'(1));
    endtask

    task automatic t_single();
        do_reset();
        for (int i = 0; i < N; i++) begin
            set_in(onehot(i), 1'b1);
            chk($sformatf("R4 lone requester %0d", i), gnt_o, onehot(i));
            do_slot();
        end
    endtask

    task automatic t_rotation();
        int cnt [N];
        do_reset();
        for (int i = 0; i < N; i++) cnt[i] = 0;
        set_in('1, 1'b1);
        for (int s = 0; s < N; s++) begin
            chk($sformatf("R9 R2 R3 slot %0d", s), gnt_o, onehot(bitrev(s)));
            for (int i = 0; i < N; i++) if (gnt_o[i]) cnt[i]++;
            do_slot();
        end
        for (int i = 0; i < N; i++)
            chk($sformatf("R9 fairness count input %0d", i), N'(cnt[i]), N'(1));
        chk("R9 wraps to input 0", gnt_o, onehot(0));
    endtask

    task automatic t_pair();
        logic [N-1:0] exp;
        do_reset();
        set_in(onehot(3) | onehot(5), 1'b1);
        for (int s = 0; s < 4; s++) begin
            exp = (s % 2 == 0) ? onehot(3) : onehot(5);
            chk($sformatf("R10 R2 pair slot %0d", s), gnt_o, exp);
            do_slot();
        end
    endtask

    task automatic t_blocked();
        do_reset();
        set_in('1, 1'b1);
        do_slot();
        set_in('1, 1'b0);
        chk("R7 no grant when blocked", gnt_o, '0);
        chk("R8 group req while blocked", N'(grp_req_o), N'(1));
        repeat (3) do_slot();
        set_in('1, 1'b1);
        chk("R7 preferences held while blocked", gnt_o, onehot(8));
    endtask

    task automatic t_hold_no_strobe();
        do_reset();
        set_in('1, 1'b1);
        repeat (5) @(negedge clk);
        chk("R12 grant stable without strobe", gnt_o, onehot(0));
        do_slot();
        chk("R12 strobe advances", gnt_o, onehot(8));
    endtask

    task automatic t_hi_side();
        do_reset();
        set_in(onehot(1), 1'b1);
        do_slot();
        set_in(onehot(0) | onehot(1), 1'b1);
        chk("R3 high-side win sets preference low", gnt_o, onehot(0));
        do_slot();
        chk("R3 low-side win sets preference high", gnt_o, onehot(1));
    endtask

    task automatic t_idle_keep();
        do_reset();
        set_in('1, 1'b1);
        do_slot();
        set_in(onehot(0), 1'b1);
        do_slot();
        set_in('0, 1'b1);
        repeat (2) do_slot();
        set_in(onehot(8) | onehot(12), 1'b1);
        do_slot();
        set_in('1, 1'b1);
        chk("R11 untouched cells keep preference", gnt_o, onehot(4));
    endtask

    initial begin
        t_reset_state();
        t_single();
        t_rotation();
        t_pair();
        t_blocked();
        t_hold_no_strobe();
        t_hi_side();
        t_idle_keep();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule